// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives three independent clock outputs meant for external pins. Each output has its own configuration: a 2-bit source code that picks among a slow clock, a main clock and a PLL clock, and a 3-bit prescaler that divides the picked source by a power of two between 1 and 64. Two write-one mask inputs turn outputs on and off. One set bit enables an output and one clear bit disables it. The block reports which outputs are running, and for each output whether it already reflects its current configuration.

All three source clocks are modelled as clock-enable pulses inside one system clock domain. Each pulse stands for one half-period event of its source, so a divider of 1 toggles the output on every pulse of the source. The block does not switch sources without glitches. Software is expected to disable an output before it rewrites that output's configuration, and to enable it again afterwards.

Each output is a small state machine with three states:

- `CH_OFF`: the output is disabled and held low.
- `CH_SYNC`: the output is enabled, the divider has restarted and the first edge has not yet appeared.
- `CH_RUN`: the output is toggling as programmed.

The transitions are:

- **enable**: `CH_OFF`→`CH_SYNC`, on a set bit with no clear bit in the same cycle.
- **first_edge**: `CH_SYNC`→`CH_RUN`, when the divider reaches its limit.
- **reconfig**: `CH_RUN`→`CH_SYNC`, or `CH_SYNC`→`CH_SYNC` with a restart, on a configuration write to that output.
- **disable**: any enabled state→`CH_OFF`, on a clear bit.

Top module: `progclk_top`

## Requirements
- R1: After reset, all of `clk_out`, `active` and `ready` are 0, and every stored configuration is source 0 with prescaler 0.
- R2: A 1 in bit i of `en_set` sets `active[i]` at the next clock edge when output i was disabled. A 0 bit has no effect.
- R3: A 1 in bit i of `en_clr` clears `active[i]`, `ready[i]` and `clk_out[i]` at the next clock edge. The clear wins when the set bit and the clear bit for the same output are high in the same cycle.
- R4: The source code selects the pulse stream that drives the divider: 0 selects `slow_tick`, 1 selects `main_tick` and 3 selects `pll_tick`. The reserved code 2 behaves as 0.
- R5: With prescaler value n, an enabled output toggles once every 2^n pulses of its selected source. The reserved value 7 behaves as 6, giving a toggle every 64 pulses.
- R6: After an output is enabled, its output stays low and `ready` stays 0 until the 2^n-th counted pulse. At that pulse the output rises and `ready` is set on the same clock edge.
- R7: A configuration write to an enabled output clears its `ready` at the next edge and drives its output low. The divider then restarts from zero with the new settings, and R6 applies again.
- R8: A configuration write to a disabled output stores the settings without enabling it. A write with `cfg_idx` of 3 or above changes no output.
- R9: A source pulse that arrives in the same cycle as an enable or a configuration write to that output is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow-clock pulse, one per source half-period |
| main_tick | input | 1 | Main-clock pulse |
| pll_tick | input | 1 | PLL-clock pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Output index targeted by the configuration write |
| cfg_src | input | 2 | Source code: 0 slow, 1 main, 3 PLL, 2 treated as slow |
| cfg_div | input | 3 | Prescaler exponent; 7 treated as 6 |
| en_set | input | 3 | Write-one enable mask, one bit per output |
| en_clr | input | 3 | Write-one disable mask, one bit per output |
| clk_out | output | 3 | Generated clock outputs |
| active | output | 3 | Output enabled status |
| ready | output | 3 | Output reflects its current configuration |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a known value on every sampled edge, including the edges during reset. They also assume that the three tick inputs are plain one-cycle qualifiers, with no relation to one another. The bench drives every input at the falling edge from a single task. It holds all strobes and masks at zero while reset is asserted. It generates the pulses from a fixed schedule: the PLL pulse is high on every cycle, the main pulse on every second cycle and the slow pulse on every fifth cycle. That schedule keeps the inputs inside these assumptions and still places pulses in the same cycles as enables and configuration writes.

// File: rtl/progclk_pkg.sv
`timescale 1ns/1ps
package progclk_pkg;

    localparam int SRC_W = 2;

    localparam logic [SRC_W-1:0] SRC_SLOW = 2'd0;
    localparam logic [SRC_W-1:0] SRC_MAIN = 2'd1;
    localparam logic [SRC_W-1:0] SRC_RSVD = 2'd2;
    localparam logic [SRC_W-1:0] SRC_PLL  = 2'd3;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_SYNC = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;

endpackage

// File: rtl/progclk_srcsel.sv
`timescale 1ns/1ps
module progclk_srcsel
    import progclk_pkg::*;
(
    input  logic [SRC_W-1:0] sel,
    input  logic             slow_tick,
    input  logic             main_tick,
    input  logic             pll_tick,
    output logic             tick
);

    // Reserved code falls back to the slow source (R4)
    always_comb begin
        unique case (sel)
            SRC_SLOW, SRC_RSVD: tick = slow_tick;
            SRC_MAIN:           tick = main_tick;
            SRC_PLL:            tick = pll_tick;
            default:            tick = slow_tick;
        endcase
    end

endmodule

// File: rtl/progclk_chan.sv
`timescale 1ns/1ps
module progclk_chan
    import progclk_pkg::*;
#(
    parameter int DIV_W   = 3,
    parameter int MAX_LOG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             main_tick,
    input  logic             pll_tick,
    input  logic             cfg_we,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             en_set,
    input  logic             en_clr,
    output logic             clk_out,
    output logic             active,
    output logic             ready
);

    localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

    ch_state_e        state_q, state_n;
    logic [SRC_W-1:0] src_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             out_q;
    logic             sel_tick;
    logic             edge_hit;
    logic             restart;

    progclk_srcsel u_sel (
        .sel       (src_q),
        .slow_tick (slow_tick),
        .main_tick (main_tick),
        .pll_tick  (pll_tick),
        .tick      (sel_tick)
    );

    // Prescaler clamp: codes above the largest exponent saturate
    always_comb begin
        if (int'(div_q) > MAX_LOG) begin
            div_eff = DIV_W'(MAX_LOG);
        end else begin
            div_eff = div_q;
        end
        lim      = CNT_W'((1 << div_eff) - 1);
        edge_hit = sel_tick && (cnt_q == lim);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    // Transitions: enable, first_edge, reconfig, disable
    always_comb begin
        state_n = state_q;
        restart = 1'b0;
        unique case (state_q)
            CH_OFF: begin
                if (en_set && !en_clr) begin
                    state_n = CH_SYNC;
                    restart = 1'b1;
                end
            end
            CH_SYNC: begin
                if (en_clr) begin
                    state_n = CH_OFF;
                end else if (cfg_we) begin
                    restart = 1'b1;
                end else if (edge_hit) begin
                    state_n = CH_RUN;
                end
            end
            CH_RUN: begin
                if (en_clr) begin
                    state_n = CH_OFF;
                end else if (cfg_we) begin
                    state_n = CH_SYNC;
                    restart = 1'b1;
                end
            end
            default: state_n = CH_OFF;
        endcase
    end

    // Stored configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= SRC_SLOW;
            div_q <= '0;
        end else if (cfg_we) begin
            src_q <= cfg_src;
            div_q <= cfg_div;
        end
    end

    // Divider counter and output flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if ((state_n == CH_OFF) || restart) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (sel_tick) begin
            if (cnt_q == lim) begin
                cnt_q <= '0;
                out_q <= ~out_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        clk_out = out_q;
        active  = (state_q != CH_OFF);
        ready   = (state_q == CH_RUN);
    end

endmodule

// File: rtl/progclk_top.sv
`timescale 1ns/1ps
module progclk_top
    import progclk_pkg::*;
#(
    parameter int  NUM_OUT = 3,
    parameter int  DIV_W   = 3,
    parameter int  MAX_LOG = 6,
    localparam int IDX_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT + 1) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_tick,
    input  logic               main_tick,
    input  logic               pll_tick,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [NUM_OUT-1:0] en_set,
    input  logic [NUM_OUT-1:0] en_clr,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] active,
    output logic [NUM_OUT-1:0] ready
);

    logic [NUM_OUT-1:0] chan_we;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
        // Out-of-range indices decode to no channel (R8)
        assign chan_we[g] = cfg_we && (cfg_idx == IDX_W'(g));

        progclk_chan #(
            .DIV_W   (DIV_W),
            .MAX_LOG (MAX_LOG)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .slow_tick (slow_tick),
            .main_tick (main_tick),
            .pll_tick  (pll_tick),
            .cfg_we    (chan_we[g]),
            .cfg_src   (cfg_src),
            .cfg_div   (cfg_div),
            .en_set    (en_set[g]),
            .en_clr    (en_clr[g]),
            .clk_out   (clk_out[g]),
            .active    (active[g]),
            .ready     (ready[g])
        );
    end

endmodule

// File: rtl/progclk_chk.sv
`timescale 1ns/1ps
module progclk_chk #(
    parameter int NUM_OUT = 3,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [IDX_W-1:0]   cfg_idx,
    input logic [NUM_OUT-1:0] en_set,
    input logic [NUM_OUT-1:0] en_clr,
    input logic [NUM_OUT-1:0] clk_out,
    input logic [NUM_OUT-1:0] active,
    input logic [NUM_OUT-1:0] ready
);

    logic [NUM_OUT-1:0] wmask;
    logic [NUM_OUT-1:0] setmask;

    always_comb begin
        for (int i = 0; i < NUM_OUT; i++) begin
            wmask[i] = cfg_we && (int'(cfg_idx) == i);
        end
        setmask = en_set & ~en_clr & ~active;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (active == '0) && (clk_out == '0) && (ready == '0)); // R1

    AST_SET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (setmask != '0) |=> ((active & $past(setmask)) == $past(setmask))); // R2

    AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr != '0) |=> ((active & $past(en_clr)) == '0)); // R3

    AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_out & ~active) == '0)); // R3

    AST_READY_WITH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready & ~$past(ready) & ~clk_out) == '0)); // R6

    AST_READY_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready & ~active) == '0)); // R6

    AST_CFG_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wmask != '0) |=> ((ready & $past(wmask)) == '0) && ((clk_out & $past(wmask)) == '0)); // R7

endmodule

bind progclk_top progclk_chk #(
    .NUM_OUT (NUM_OUT),
    .IDX_W   (IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_idx (cfg_idx),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .clk_out (clk_out),
    .active  (active),
    .ready   (ready)
);

// File: tb/tb_progclk_top.sv
`timescale 1ns/1ps
module tb_progclk_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0, main_tick = 1'b0, pll_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic [1:0] cfg_src = '0;
    logic [2:0] cfg_div = '0;
    logic [2:0] en_set = '0, en_clr = '0;
    logic [2:0] clk_out, active, ready;

    int    checks = 0;
    int    fails = 0;
    int    tcount = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference model state: 0 off, 1 waiting first edge, 2 running
    int   m_st[3];
    int   m_cnt[3];
    int   m_src[3];
    int   m_div[3];
    logic [2:0] m_out = '0;

    always #5 clk = ~clk;

    progclk_top dut (
        .clk(clk), .rst_n(rst_n),
        .slow_tick(slow_tick), .main_tick(main_tick), .pll_tick(pll_tick),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_src(cfg_src), .cfg_div(cfg_div),
        .en_set(en_set), .en_clr(en_clr),
        .clk_out(clk_out), .active(active), .ready(ready)
    );

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_st[i] = 0; m_cnt[i] = 0; m_src[i] = 0; m_div[i] = 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_st[i] = 0; m_cnt[i] = 0; m_src[i] = 0; m_div[i] = 0; m_out[i] = 1'b0;
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                bit t;
                bit w;
                int d;
                w = cfg_we && (int'(cfg_idx) == i);
                case (m_src[i])
                    1:       t = main_tick;
                    3:       t = pll_tick;
                    default: t = slow_tick;
                endcase
                d = (m_div[i] > 6) ? 6 : m_div[i];
                if (en_clr[i]) begin
                    m_st[i] = 0; m_cnt[i] = 0; m_out[i] = 1'b0;
                end else if (m_st[i] == 0) begin
                    if (en_set[i]) begin
                        m_st[i] = 1; m_cnt[i] = 0; m_out[i] = 1'b0;
                    end
                end else if (w) begin
                    m_st[i] = 1; m_cnt[i] = 0; m_out[i] = 1'b0;
                end else if (t) begin
                    m_cnt[i]++;
                    if (m_cnt[i] == (1 << d)) begin
                        m_cnt[i] = 0;
                        m_out[i] = ~m_out[i];
                        if (m_st[i] == 1) m_st[i] = 2;
                    end
                end
                if (w) begin
                    m_src[i] = int'(cfg_src);
                    m_div[i] = int'(cfg_div);
                end
            end
        end
    end

    task automatic compare();
        logic [2:0] e_act, e_rdy;
        for (int i = 0; i < 3; i++) begin
            e_act[i] = (m_st[i] != 0);
            e_rdy[i] = (m_st[i] == 2);
        end
        checks += 3;
        if (clk_out !== m_out) begin
            fails++;
            $display("FAIL %s clk_out actual=%b expected=%b t=%0t", tag, clk_out, m_out, $time);
        end
        if (active !== e_act) begin
            fails++;
            $display("FAIL %s active actual=%b expected=%b t=%0t", tag, active, e_act, $time);
        end
        if (ready !== e_rdy) begin
            fails++;
            $display("FAIL %s ready actual=%b expected=%b t=%0t", tag, ready, e_rdy, $time);
        end
    endtask

    // One cycle: check at the falling edge, then drive the next inputs
    task automatic cyc(input logic [2:0] s, input logic [2:0] c, input logic we,
                       input logic [1:0] idx, input logic [1:0] src, input logic [2:0] dv);
        @(negedge clk);
        compare();
        tcount++;
        pll_tick  = 1'b1;
        main_tick = (tcount % 2) == 0;
        slow_tick = (tcount % 5) == 0;
        en_set = s; en_clr = c; cfg_we = we; cfg_idx = idx; cfg_src = src; cfg_div = dv;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(3'b000, 3'b000, 1'b0, 2'd0, 2'd0, 3'd0);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [1:0] src, input logic [2:0] dv);
        cyc(3'b000, 3'b000, 1'b1, idx, src, dv);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        idle(4);
        @(negedge clk);
        rst_n = 1'b1;
        idle(4);

        // R8: configuration while disabled, and an out-of-range index
        tag = "R8";
        wr(2'd0, 2'd1, 3'd0);
        wr(2'd1, 2'd3, 3'd2);
        wr(2'd2, 2'd0, 3'd1);
        wr(2'd3, 2'd3, 3'd5);
        idle(8);

        // R2, R6, R9: enable all outputs; ticks are present in the enable cycle
        tag = "R2";
        cyc(3'b111, 3'b000, 1'b0, 2'd0, 2'd0, 3'd0);
        tag = "R6";
        idle(12);
        tag = "R5";
        idle(60);

        // R7: reconfigure a running output to the reserved prescaler code
        tag = "R7";
        wr(2'd1, 2'd3, 3'd7);
        idle(20);
        tag = "R5";
        idle(200);

        // R4: source codes, including the reserved code 2
        tag = "R4";
        cyc(3'b000, 3'b100, 1'b0, 2'd0, 2'd0, 3'd0);
        wr(2'd2, 2'd2, 3'd0);
        cyc(3'b100, 3'b000, 1'b0, 2'd0, 2'd0, 3'd0);
        idle(40);
        wr(2'd0, 2'd3, 3'd3);
        idle(60);
        wr(2'd0, 2'd1, 3'd2);
        idle(60);

        // R9: config write on a running output in a cycle that also has a tick
        tag = "R9";
        wr(2'd2, 2'd3, 3'd0);
        idle(10);

        // R3: clear wins over set on the same bit, then plain clear
        tag = "R3";
        cyc(3'b010, 3'b010, 1'b0, 2'd0, 2'd0, 3'd0);
        idle(10);
        cyc(3'b000, 3'b001, 1'b0, 2'd0, 2'd0, 3'd0);
        idle(10);
        cyc(3'b011, 3'b000, 1'b0, 2'd0, 2'd0, 3'd0);
        tag = "R5";
        idle(150);
        tag = "R3";
        cyc(3'b000, 3'b111, 1'b0, 2'd0, 2'd0, 3'd0);
        idle(6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule